// File: doc/BRIEF.md
# Prioritized Status LED Driver

This block turns a handful of device condition flags into the light patterns of a green and a red status LED. Five conditions are ranked: a reset or field-supply overload, a fault reported by the attached sensor and actuator circuitry, an unprogrammed (zero) address, an expired communication watchdog, and plain regular operation. The highest-ranked active condition alone decides the pattern. Each LED is steadily on, steadily off, blinking, or blinking in antiphase to the other LED.

A blink phase comes from a clock-enable divider that flips every half period. The divider uses the system clock, with the period set by parameters to a rate of two to three hertz. The fault input arrives low-active from outside the clock domain and passes through a two-stage synchronizer. A soft reset clears that synchronizer and leaves the blink divider alone, so the blink rhythm has no hiccup when the rest of the device restarts. Only the hard reset (`rst_n`) restarts the divider.

Top module: `led_status_drv`

## Requirements
- R1: While `rst_n` is low both LEDs are off (`led_g` = 0, `led_r` = 0), and the blink phase restarts at "dark".
- R2: With only regular operation active, green is steadily on and red is steadily off.
- R3: With the watchdog flag active as the top-ranked condition, green is off and red is steadily on.
- R4: With the zero-address flag active as the top-ranked condition, green blinks and red is steadily on.
- R5: With the fault input low as the top-ranked condition, green blinks and red shows the inverse of green.
- R6: With the reset/overload flag active, green is off and red blinks.
- R7: Ranking from highest to lowest is: reset/overload, fault, zero address, watchdog, regular operation.
- R8: With no condition active, both LEDs are off.
- R9: A blinking LED stays dark for HALF cycles and then lit for HALF cycles, with a 50% duty cycle. HALF is CLK_HZ*50/BLINK_CHZ. After the hard reset is released, the output updated at clock edge n shows lit when floor((n-1)/HALF) is odd.
- R10: Asserting `soft_rst` does not shift or restart the blink phase.
- R11: A change on the level flags appears at the LEDs at the first clock edge. A change on `fault_n_i` appears at the third edge.
- R12: A one-cycle `soft_rst` clears the fault synchronizer. With the fault held low, the outputs written at the first and second edges after the soft-reset edge show the no-fault pattern, and the fault pattern comes back at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset, clears the fault synchronizer only |
| ovl_i | input | 1 | External reset or field-supply overload flag |
| fault_n_i | input | 1 | Periphery fault, active low, asynchronous |
| addr_zero_i | input | 1 | Address is zero or invalid |
| wdog_i | input | 1 | Communication watchdog expired |
| run_i | input | 1 | Regular operation |
| led_g | output | 1 | Green LED, 1 = lit |
| led_r | output | 1 | Red LED, 1 = lit |

## Verification
The level flags pass through a single output register, so their result is due one edge after they change. The fault input passes through two more stages first, so its result is due three edges after it changes. The bench changes inputs on falling edges and waits three rising edges before it checks any table entry. Directed cases sample exactly at the first, second and third edge to fix those latencies. Blink values are predicted from the bench's own count of rising edges since the hard reset was released, using the formula in R9. Because the bench only counts edges, a soft reset that disturbed the divider would show up as a mismatch.

// File: rtl/led_status_drv.sv
module led_status_drv #(
  parameter int unsigned CLK_HZ    = 5_333_333,
  parameter int unsigned BLINK_CHZ = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic ovl_i,
  input  logic fault_n_i,
  input  logic addr_zero_i,
  input  logic wdog_i,
  input  logic run_i,
  output logic led_g,
  output logic led_r
);

  localparam logic [63:0] HALF_L = (64'(CLK_HZ) * 64'd50) / 64'(BLINK_CHZ);
  localparam int unsigned HALF = (HALF_L < 64'd2) ? 2 : int'(HALF_L[31:0]);
  localparam int unsigned CW = $clog2(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          phase;
  logic          flt_m, flt_q;
  logic          g_d, r_d;

  // blink timebase: hard reset only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // fault synchronizer, cleared by both resets
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_m <= 1'b1;
      flt_q <= 1'b1;
    end else if (soft_rst) begin
      flt_m <= 1'b1;
      flt_q <= 1'b1;
    end else begin
      flt_m <= fault_n_i;
      flt_q <= flt_m;
    end
  end

  always_comb begin
    g_d = 1'b0;
    r_d = 1'b0;
    if (ovl_i) begin
      r_d = phase;
    end else if (!flt_q) begin
      g_d = phase;
      r_d = ~phase;
    end else if (addr_zero_i) begin
      g_d = phase;
      r_d = 1'b1;
    end else if (wdog_i) begin
      r_d = 1'b1;
    end else if (run_i) begin
      g_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_g <= 1'b0;
      led_r <= 1'b0;
    end else begin
      led_g <= g_d;
      led_r <= r_d;
    end
  end

  a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != LAST) |=> $stable(phase));

  a_r10_soft_keeps_timer: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (phase == (($past(cnt) == LAST) ? !$past(phase) : $past(phase))));

  a_r6_green_dark: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_i |=> !led_g);

  a_r5_antiphase: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovl_i && !flt_q) |=> (led_g != led_r));

  a_r4_red_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovl_i && flt_q && addr_zero_i) |=> led_r);

  a_r2_regular: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !ovl_i && flt_q && !addr_zero_i && !wdog_i) |=> (led_g && !led_r));

endmodule

// File: tb/led_status_drv_test.sv
module led_status_drv_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic ovl = 1'b0, fn = 1'b1, az = 1'b0, wd = 1'b0, run = 1'b0;
  logic led_g, led_r;
  int   total = 0;
  int   fails = 0;
  int   edges;

  led_status_drv #(.CLK_HZ(1000), .BLINK_CHZ(10000)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ovl_i(ovl), .fault_n_i(fn),
    .addr_zero_i(az), .wdog_i(wd), .run_i(run), .led_g(led_g), .led_r(led_r));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;

  // flags {ovl, fault_n, az, wd, run}, then green code, red code
  // codes: 0 off, 1 on, 2 blink, 3 inverse blink
  localparam int NV = 10;
  localparam logic [8:0] VEC [NV] = '{
    {5'b01001, 2'd1, 2'd0},  // R2 regular
    {5'b01011, 2'd0, 2'd1},  // R3 R7 watchdog over regular
    {5'b01101, 2'd2, 2'd1},  // R4 zero address
    {5'b01110, 2'd2, 2'd1},  // R7 zero address over watchdog
    {5'b00001, 2'd2, 2'd3},  // R5 fault
    {5'b00111, 2'd2, 2'd3},  // R7 fault over address and watchdog
    {5'b11000, 2'd0, 2'd2},  // R6 overload
    {5'b10111, 2'd0, 2'd2},  // R7 overload over everything
    {5'b01000, 2'd0, 2'd0},  // R8 nothing active
    {5'b01010, 2'd0, 2'd1}   // R3 watchdog alone
  };
  localparam int TAG [NV] = '{2, 3, 4, 7, 5, 7, 6, 7, 8, 3};

  function automatic logic ph();
    if (edges < 1) return 1'b0;
    return 1'(((edges - 1) / HALF) % 2);
  endfunction

  function automatic logic dec(input logic [1:0] c);
    case (c)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return ph();
      default: return ~ph();
    endcase
  endfunction

  task automatic chk(input string tag, input logic eg, input logic er);
    total++;
    if (led_g !== eg || led_r !== er) begin
      fails++;
      $display("FAIL %s: got g=%b r=%b expected g=%b r=%b", tag, led_g, led_r, eg, er);
    end
  endtask

  task automatic setf(input logic [4:0] f);
    {ovl, fn, az, wd, run} = f;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1 reset state
    setf(5'b01100);
    repeat (3) @(negedge clk);
    chk("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    // R9 dark for HALF edges, then lit
    repeat (HALF) @(negedge clk);
    chk("R9 dark", 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 lit", 1'b1, 1'b1);
    repeat (HALF - 1) @(negedge clk);
    chk("R9 lit end", 1'b1, 1'b1);
    @(negedge clk);
    chk("R9 dark again", 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      setf(VEC[i][8:4]);
      repeat (3) @(negedge clk);
      for (int k = 0; k < 2 * HALF; k++) begin
        chk($sformatf("R%0d vec%0d", TAG[i], i), dec(VEC[i][3:2]), dec(VEC[i][1:0]));
        @(negedge clk);
      end
    end

    // R11 latency of a level flag
    setf(5'b01001);
    repeat (3) @(negedge clk);
    wd = 1'b1;
    @(negedge clk);
    chk("R11 level one edge", 1'b0, 1'b1);
    // R11 latency of the fault input
    fn = 1'b0;
    @(negedge clk);
    chk("R11 fault edge1", 1'b0, 1'b1);
    @(negedge clk);
    chk("R11 fault edge2", 1'b0, 1'b1);
    @(negedge clk);
    chk("R11 fault edge3", ph(), ~ph());

    // R12 soft reset clears synchronizer
    wd = 1'b0;
    repeat (2) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R12 soft edge", ph(), ~ph());
    @(negedge clk);
    chk("R12 edge1", 1'b1, 1'b0);
    @(negedge clk);
    chk("R12 edge2", 1'b1, 1'b0);
    @(negedge clk);
    chk("R12 edge3", ph(), ~ph());

    // R10 soft reset keeps blink rhythm
    setf(5'b01100);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3 * HALF; k++) begin
      soft_rst = (k % 4 == 1);
      @(negedge clk);
      chk("R10", ph(), 1'b1);
    end
    soft_rst = 1'b0;

    // R1 hard reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 again", 1'b0, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule